// File: doc/BRIEF.md
# Memory-to-Memory Copy Engine with Descriptor Ring

The block moves data from one memory region to another with no processor involvement. It reads source elements through a dedicated read master and writes them through a separate write master. Each master uses a simple request channel (valid/ready with start address, beat count and element size), followed by a beat channel. Every beat carries one element in the low bits of a 32-bit word, and element k of a request lies at start address + k × element bytes. The read beat channel has no back-pressure. The write beat channel has a ready signal.

Software can start a copy in two ways. In direct mode it writes the source, destination and transfer word, then sets the direct-start bit. In ring mode the block walks a circular list of four-word descriptors. For each valid entry it runs the copy, marks the entry consumed in memory and moves on to the next. When it meets an invalid entry it parks and flags a stall. Every finished copy raises a sticky interrupt flag.

Top module: `memcopy_dma`

## Requirements
- R1: Source elements and descriptors are fetched only on the read master, and destination elements and descriptor status words are written only on the write master. No read request targets a destination region, and no write request targets a source region.
- R2: Register map by word index: 0 source address, 1 destination address, 2 transfer word, 3 start, 4 ring base, 5 ring length, 6 status. Writing 1 to start bit 0 while idle begins a direct copy from the programmed source. No descriptor is fetched first.
- R3: A descriptor at ring base + 16 × index (the base is aligned to 16) is read as one 4-beat word request. It holds the source at +0, the destination at +4, a transfer word at +8 and a control word at +12, whose bit 0 is the valid flag. Writing 1 to start bit 1 while idle begins ring mode.
- R4: When a fetched descriptor has bit 0 clear, the engine sets status bit 1 (stall, write-one-to-clear), goes idle and keeps its ring index. A later ring start fetches that same entry again.
- R5: After a descriptor's copy, the engine writes the single word 0x0000_0002 (valid cleared, completed set) to the entry's control word at +12.
- R6: After the entry at index ring length − 1, the next fetch is index 0.
- R7: Transfer-word bits [19:18] set the burst: 0 gives 1 beat, 1 gives 4, 2 gives 8 and 3 gives 16. Each read request carries that many beats, except the last, which carries the remaining elements. The number of requests is the element count divided by the burst, rounded up.
- R8: Transfer-word bits [15:0] give the element count and bits [17:16] the size (0 byte, 1 halfword, 2 word). Addresses advance by 1, 2 or 4 bytes per element, and the destination receives each element at the matching offset.
- R9: When transfer-word bit 20 is set, the bytes of each halfword or word element are reversed before the write. For byte elements the bit has no effect.
- R10: Every finished copy, direct or from a descriptor, sets status bit 0. The irq output follows that bit and stays high until software writes 1 to status bit 0.
- R11: A direct copy with an element count of 0 finishes at once, with irq set and no request on either master.
- R12: Status bit 2 reads 1 while the engine is busy. Start writes and source or destination changes made while it is busy do not alter or repeat the copy in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| irq | output | 1 | Copy-complete interrupt |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 32 | Read burst start address |
| rd_req_beats | output | 5 | Read burst beat count (1..16) |
| rd_req_size | output | 2 | Read element size code |
| rd_beat_valid | input | 1 | Read data beat valid |
| rd_beat_data | input | 32 | Read data beat |
| wr_req_valid | output | 1 | Write request valid |
| wr_req_ready | input | 1 | Write request accepted |
| wr_req_addr | output | 32 | Write burst start address |
| wr_req_beats | output | 5 | Write burst beat count (1..16) |
| wr_req_size | output | 2 | Write element size code |
| wr_beat_valid | output | 1 | Write data beat valid |
| wr_beat_ready | input | 1 | Write data beat accepted |
| wr_beat_data | output | 32 | Write data beat |

## Verification
The hardest situation to reach is the wrap from the last ring entry back to an entry the engine has already consumed, followed by a restart that must resume at the stalled index rather than the next one. The bench builds a three-entry ring in its memory model and lets the engine clear every valid flag. It then confirms that the fourth fetch reads entry 0 and stalls. Next it revalidates only entry 0 and restarts, and expects exactly one more copy followed by a stall on entry 1. The request and beat channels are throttled with different ready patterns throughout, so every hold state of the sequencer is reached.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  localparam int ADDR_W      = 32;
  localparam int DATA_W      = 32;
  localparam int XFER_CNT_W  = 16;
  localparam int BEAT_W      = 5;
  localparam int XFER_W      = XFER_CNT_W + 5;
  localparam int DESC_WORDS  = 4;
  localparam logic [DATA_W-1:0] WB_WORD = 32'h0000_0002;

  typedef enum logic [3:0] {
    S_IDLE, S_DREQ, S_DDATA, S_RREQ, S_RDATA,
    S_WREQ, S_WDATA, S_BREQ, S_BDATA, S_DONE
  } seq_state_e;

  typedef struct packed {
    logic                  swap;
    logic [1:0]            burst;
    logic [1:0]            size;
    logic [XFER_CNT_W-1:0] count;
  } xfer_cfg_t;

  function automatic logic [BEAT_W-1:0] burst_beats(input logic [1:0] code);
    case (code)
      2'd0:    return BEAT_W'(1);
      2'd1:    return BEAT_W'(4);
      2'd2:    return BEAT_W'(8);
      default: return BEAT_W'(16);
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] span_bytes(input logic [BEAT_W-1:0] n,
                                                   input logic [1:0] size);
    case (size)
      2'd0:    return ADDR_W'(n);
      2'd1:    return ADDR_W'(n) << 1;
      default: return ADDR_W'(n) << 2;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] entry_addr(input logic [ADDR_W-1:0] base,
                                                   input logic [ADDR_W-1:0] idx);
    return {base[ADDR_W-1:4], 4'h0} + (idx << 4);
  endfunction
endpackage

// File: rtl/mcd_swap.sv
module mcd_swap
  import mcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        size,
  input  logic              en,
  output logic [DATA_W-1:0] dout
);
  localparam int LANES = DATA_W / 8;

  logic word_mode, half_mode;
  assign word_mode = en && (size >= 2'd2);
  assign half_mode = en && (size == 2'd1);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int WSRC = LANES - 1 - g;
    localparam int HSRC = (g < 2) ? (1 - g) : g;
    assign dout[8*g +: 8] = word_mode ? din[8*WSRC +: 8] :
                            half_mode ? din[8*HSRC +: 8] : din[8*g +: 8];
  end

  p_byte_passthru_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (size == 2'd0) |-> (dout == din));
  p_word_reverse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && size == 2'd2) |-> (dout[31:24] == din[7:0] && dout[7:0] == din[31:24]));
endmodule

// File: rtl/mcd_regs.sv
module mcd_regs
  import mcd_pkg::*;
#(
  parameter int RIDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              busy,
  input  logic              evt_done,
  input  logic              evt_stall,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output xfer_cfg_t         xfer,
  output logic [ADDR_W-1:0] ring_base,
  output logic [RIDX_W-1:0] ring_len,
  output logic              start_single,
  output logic              start_ring,
  output logic              irq
);
  localparam logic [2:0] A_SRC = 3'd0, A_DST = 3'd1, A_XFER = 3'd2, A_GO = 3'd3,
                         A_RBASE = 3'd4, A_RLEN = 3'd5, A_STAT = 3'd6;

  logic done_q, stall_q, clr_done, clr_stall;
  logic go_write;

  assign go_write     = cfg_we && cfg_addr == A_GO && !busy;
  assign start_single = go_write && cfg_wdata[0];
  assign start_ring   = go_write && !cfg_wdata[0] && cfg_wdata[1];
  assign clr_done     = cfg_we && cfg_addr == A_STAT && cfg_wdata[0];
  assign clr_stall    = cfg_we && cfg_addr == A_STAT && cfg_wdata[1];
  assign irq          = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_addr  <= '0;
      dst_addr  <= '0;
      xfer      <= '0;
      ring_base <= '0;
      ring_len  <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        A_SRC:   src_addr  <= cfg_wdata;
        A_DST:   dst_addr  <= cfg_wdata;
        A_XFER:  xfer      <= cfg_wdata[XFER_W-1:0];
        A_RBASE: ring_base <= cfg_wdata;
        A_RLEN:  ring_len  <= cfg_wdata[RIDX_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      done_q  <= evt_done  | (done_q  & ~clr_done);
      stall_q <= evt_stall | (stall_q & ~clr_stall);
    end
  end

  always_comb begin
    case (cfg_addr)
      A_SRC:   cfg_rdata = src_addr;
      A_DST:   cfg_rdata = dst_addr;
      A_XFER:  cfg_rdata = 32'(xfer);
      A_RBASE: cfg_rdata = ring_base;
      A_RLEN:  cfg_rdata = 32'(ring_len);
      A_STAT:  cfg_rdata = {29'd0, busy, stall_q, done_q};
      default: cfg_rdata = '0;
    endcase
  end

  p_done_sets_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> irq);
  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_done) |=> irq);
  p_no_start_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(start_single || start_ring));
endmodule

// File: rtl/mcd_seq.sv
module mcd_seq
  import mcd_pkg::*;
#(
  parameter int RIDX_W    = 8,
  parameter int MAX_BURST = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_single,
  input  logic              start_ring,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  xfer_cfg_t         cfg_xfer,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [RIDX_W-1:0] ring_len,
  output logic              busy,
  output logic              evt_done,
  output logic              evt_stall,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  output logic [BEAT_W-1:0] rd_req_beats,
  output logic [1:0]        rd_req_size,
  input  logic              rd_beat_valid,
  input  logic [DATA_W-1:0] rd_beat_data,
  output logic              wr_req_valid,
  input  logic              wr_req_ready,
  output logic [ADDR_W-1:0] wr_req_addr,
  output logic [BEAT_W-1:0] wr_req_beats,
  output logic [1:0]        wr_req_size,
  output logic              wr_beat_valid,
  input  logic              wr_beat_ready,
  output logic [DATA_W-1:0] wr_raw_data,
  output logic              swap_on
);
  localparam int BIDX_W = $clog2(MAX_BURST);

  seq_state_e             state_q;
  logic [ADDR_W-1:0]      src_q, dst_q;
  logic [XFER_CNT_W-1:0]  remain_q;
  logic [1:0]             size_q, burst_q;
  logic                   swap_q, ring_q;
  logic [RIDX_W-1:0]      ridx_q, ridx_next;
  logic [BEAT_W-1:0]      beat_cnt_q, beat_n_q, blen, next_n;
  logic [DATA_W-1:0]      stage_q [MAX_BURST];
  logic [ADDR_W-1:0]      cur_entry;
  xfer_cfg_t              desc_xfer;
  logic                   desc_last_beat, rd_last_beat, wr_last_beat, last_burst;

  assign blen      = burst_beats(burst_q);
  assign next_n    = (remain_q < XFER_CNT_W'(blen)) ? remain_q[BEAT_W-1:0] : blen;
  assign cur_entry = entry_addr(ring_base, ADDR_W'(ridx_q));
  assign desc_xfer = rd_beat_data[XFER_W-1:0];
  assign ridx_next = ({1'b0, ridx_q} + 1'b1 >= {1'b0, ring_len}) ? '0 : ridx_q + 1'b1;

  assign desc_last_beat = state_q == S_DDATA && rd_beat_valid && beat_cnt_q == BEAT_W'(DESC_WORDS - 1);
  assign rd_last_beat   = beat_cnt_q == beat_n_q - 1'b1;
  assign wr_last_beat   = beat_cnt_q == beat_n_q - 1'b1;
  assign last_burst     = remain_q == XFER_CNT_W'(beat_n_q);

  assign busy      = state_q != S_IDLE;
  assign evt_done  = state_q == S_DONE;
  assign evt_stall = desc_last_beat && !rd_beat_data[0];

  always_comb begin
    rd_req_valid  = 1'b0;
    rd_req_addr   = src_q;
    rd_req_beats  = next_n;
    rd_req_size   = size_q;
    wr_req_valid  = 1'b0;
    wr_req_addr   = dst_q;
    wr_req_beats  = beat_n_q;
    wr_req_size   = size_q;
    wr_beat_valid = 1'b0;
    wr_raw_data   = stage_q[beat_cnt_q[BIDX_W-1:0]];
    swap_on       = swap_q;
    case (state_q)
      S_DREQ: begin
        rd_req_valid = 1'b1;
        rd_req_addr  = cur_entry;
        rd_req_beats = BEAT_W'(DESC_WORDS);
        rd_req_size  = 2'd2;
      end
      S_RREQ:  rd_req_valid  = 1'b1;
      S_WREQ:  wr_req_valid  = 1'b1;
      S_WDATA: wr_beat_valid = 1'b1;
      S_BREQ: begin
        wr_req_valid = 1'b1;
        wr_req_addr  = cur_entry + ADDR_W'(12);
        wr_req_beats = BEAT_W'(1);
        wr_req_size  = 2'd2;
      end
      S_BDATA: begin
        wr_beat_valid = 1'b1;
        wr_raw_data   = WB_WORD;
        wr_req_size   = 2'd2;
        swap_on       = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (state_q == S_RDATA && rd_beat_valid)
      stage_q[beat_cnt_q[BIDX_W-1:0]] <= rd_beat_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      src_q      <= '0;
      dst_q      <= '0;
      remain_q   <= '0;
      size_q     <= '0;
      burst_q    <= '0;
      swap_q     <= 1'b0;
      ring_q     <= 1'b0;
      ridx_q     <= '0;
      beat_cnt_q <= '0;
      beat_n_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (start_single) begin
            src_q    <= cfg_src;
            dst_q    <= cfg_dst;
            remain_q <= cfg_xfer.count;
            size_q   <= cfg_xfer.size;
            burst_q  <= cfg_xfer.burst;
            swap_q   <= cfg_xfer.swap;
            ring_q   <= 1'b0;
            state_q  <= (cfg_xfer.count == '0) ? S_DONE : S_RREQ;
          end else if (start_ring) begin
            ring_q  <= 1'b1;
            state_q <= S_DREQ;
          end
        end
        S_DREQ: if (rd_req_ready) begin
          beat_cnt_q <= '0;
          state_q    <= S_DDATA;
        end
        S_DDATA: if (rd_beat_valid) begin
          beat_cnt_q <= beat_cnt_q + 1'b1;
          case (beat_cnt_q[1:0])
            2'd0: src_q <= rd_beat_data;
            2'd1: dst_q <= rd_beat_data;
            2'd2: begin
              remain_q <= desc_xfer.count;
              size_q   <= desc_xfer.size;
              burst_q  <= desc_xfer.burst;
              swap_q   <= desc_xfer.swap;
            end
            default: state_q <= !rd_beat_data[0] ? S_IDLE :
                                (remain_q == '0) ? S_BREQ : S_RREQ;
          endcase
        end
        S_RREQ: if (rd_req_ready) begin
          beat_n_q   <= next_n;
          beat_cnt_q <= '0;
          state_q    <= S_RDATA;
        end
        S_RDATA: if (rd_beat_valid) begin
          if (rd_last_beat) begin
            beat_cnt_q <= '0;
            state_q    <= S_WREQ;
          end else begin
            beat_cnt_q <= beat_cnt_q + 1'b1;
          end
        end
        S_WREQ: if (wr_req_ready) state_q <= S_WDATA;
        S_WDATA: if (wr_beat_ready) begin
          if (wr_last_beat) begin
            src_q      <= src_q + span_bytes(beat_n_q, size_q);
            dst_q      <= dst_q + span_bytes(beat_n_q, size_q);
            remain_q   <= remain_q - XFER_CNT_W'(beat_n_q);
            beat_cnt_q <= '0;
            state_q    <= !last_burst ? S_RREQ : (ring_q ? S_BREQ : S_DONE);
          end else begin
            beat_cnt_q <= beat_cnt_q + 1'b1;
          end
        end
        S_BREQ:  if (wr_req_ready) state_q <= S_BDATA;
        S_BDATA: if (wr_beat_ready) state_q <= S_DONE;
        S_DONE: begin
          if (ring_q) begin
            ridx_q  <= ridx_next;
            state_q <= S_DREQ;
          end else begin
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_rd_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));
  p_wr_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_valid && !wr_req_ready) |=> (wr_req_valid && $stable(wr_req_addr)));
  p_burst_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RREQ) |-> (rd_req_beats != '0 && rd_req_beats <= burst_beats(burst_q)));
  p_stall_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stall |=> !busy);
  p_ring_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DREQ && ring_len != '0) |-> (ridx_q < ring_len));
  p_wb_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_BREQ) |-> (wr_req_addr[3:0] == 4'hC && wr_req_beats == BEAT_W'(1)));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> !evt_done);
endmodule

// File: rtl/memcopy_dma.sv
module memcopy_dma
  import mcd_pkg::*;
#(
  parameter int RIDX_W    = 8,
  parameter int MAX_BURST = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        irq,
  output logic        rd_req_valid,
  input  logic        rd_req_ready,
  output logic [31:0] rd_req_addr,
  output logic [4:0]  rd_req_beats,
  output logic [1:0]  rd_req_size,
  input  logic        rd_beat_valid,
  input  logic [31:0] rd_beat_data,
  output logic        wr_req_valid,
  input  logic        wr_req_ready,
  output logic [31:0] wr_req_addr,
  output logic [4:0]  wr_req_beats,
  output logic [1:0]  wr_req_size,
  output logic        wr_beat_valid,
  input  logic        wr_beat_ready,
  output logic [31:0] wr_beat_data
);
  logic              busy, evt_done, evt_stall, start_single, start_ring, swap_on;
  logic [ADDR_W-1:0] src_addr, dst_addr, ring_base;
  logic [RIDX_W-1:0] ring_len;
  xfer_cfg_t         xfer;
  logic [DATA_W-1:0] wr_raw_data;

  mcd_regs #(.RIDX_W(RIDX_W)) regs_i (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .busy, .evt_done, .evt_stall,
    .src_addr, .dst_addr, .xfer, .ring_base, .ring_len,
    .start_single, .start_ring, .irq
  );

  mcd_seq #(.RIDX_W(RIDX_W), .MAX_BURST(MAX_BURST)) seq_i (
    .clk, .rst_n, .start_single, .start_ring,
    .cfg_src(src_addr), .cfg_dst(dst_addr), .cfg_xfer(xfer),
    .ring_base, .ring_len, .busy, .evt_done, .evt_stall,
    .rd_req_valid, .rd_req_ready, .rd_req_addr, .rd_req_beats, .rd_req_size,
    .rd_beat_valid, .rd_beat_data,
    .wr_req_valid, .wr_req_ready, .wr_req_addr, .wr_req_beats, .wr_req_size,
    .wr_beat_valid, .wr_beat_ready, .wr_raw_data, .swap_on
  );

  mcd_swap swap_i (
    .clk, .rst_n, .din(wr_raw_data), .size(wr_req_size), .en(swap_on),
    .dout(wr_beat_data)
  );
endmodule

// File: tb/memcopy_dma_tb_top.sv
module memcopy_dma_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, cfg_we, irq;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        rd_req_valid, rd_req_ready, rd_beat_valid;
  logic [31:0] rd_req_addr, rd_beat_data;
  logic [4:0]  rd_req_beats, wr_req_beats;
  logic [1:0]  rd_req_size, wr_req_size;
  logic        wr_req_valid, wr_req_ready, wr_beat_valid, wr_beat_ready;
  logic [31:0] wr_req_addr, wr_beat_data;

  memcopy_dma dut_i (.*);

  logic [7:0] mem [4096];
  int n_checks = 0, n_fail = 0;
  int rd_reqs, wr_reqs, last_rd_len, max_rd_len, bad_rd = 0, bad_wr = 0;
  int fetch_e0, fetch_e1;
  logic [31:0] first_rd_addr;
  bit summary_done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!summary_done) begin
      summary_done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  function automatic int nbytes(input logic [1:0] s);
    return (s == 0) ? 1 : (s == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] mem_rd(input logic [31:0] a, input logic [1:0] s);
    logic [31:0] v = '0;
    for (int i = 0; i < nbytes(s); i++) v[8*i +: 8] = mem[(a + i) & 32'hFFF];
    return v;
  endfunction

  task automatic mem_wr(input logic [31:0] a, input logic [1:0] s, input logic [31:0] d);
    for (int i = 0; i < nbytes(s); i++) mem[(a + i) & 32'hFFF] = d[8*i +: 8];
  endtask

  // memory model: read and write responders with throttled ready
  initial begin
    int rb_left = 0, wb_left = 0, tick = 0;
    logic [31:0] rb_addr = '0, wb_addr = '0;
    logic [1:0]  rb_sz = '0, wb_sz = '0;
    rd_req_ready = 0; wr_req_ready = 0; wr_beat_ready = 0;
    rd_beat_valid = 0; rd_beat_data = '0;
    forever begin
      @(negedge clk);
      tick++;
      rd_beat_valid = 0;
      if (!rst_n) begin
        rb_left = 0; wb_left = 0;
        rd_req_ready = 0; wr_req_ready = 0; wr_beat_ready = 0;
      end else begin
        if (rb_left > 0) begin
          rd_req_ready  = 0;
          rd_beat_valid = 1;
          rd_beat_data  = mem_rd(rb_addr, rb_sz);
          rb_addr += nbytes(rb_sz);
          rb_left--;
        end else begin
          rd_req_ready = (tick % 3) != 0;
          if (rd_req_valid && rd_req_ready) begin
            if (rd_reqs == 0) first_rd_addr = rd_req_addr;
            rd_reqs++;
            last_rd_len = rd_req_beats;
            if (rd_req_beats != 4 || rd_req_addr >= 32'h400) begin
              if (int'(rd_req_beats) > max_rd_len) max_rd_len = rd_req_beats;
            end
            if (rd_req_addr == 32'h100) fetch_e0++;
            if (rd_req_addr == 32'h110) fetch_e1++;
            if (rd_req_addr >= 32'h800 && rd_req_addr < 32'hA00) bad_rd++;
            rb_left = rd_req_beats; rb_addr = rd_req_addr; rb_sz = rd_req_size;
          end
        end
        if (wb_left > 0) begin
          wr_req_ready  = 0;
          wr_beat_ready = (tick % 2) == 0;
          if (wr_beat_valid && wr_beat_ready) begin
            mem_wr(wb_addr, wb_sz, wr_beat_data);
            wb_addr += nbytes(wb_sz);
            wb_left--;
          end
        end else begin
          wr_beat_ready = 0;
          wr_req_ready  = (tick % 4) != 1;
          if (wr_req_valid && wr_req_ready) begin
            wr_reqs++;
            if (wr_req_addr >= 32'h400 && wr_req_addr < 32'h600) bad_wr++;
            wb_left = wr_req_beats; wb_addr = wr_req_addr; wb_sz = wr_req_size;
          end
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    finish_up();
  end

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0; cfg_addr = 3'd6;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic wait_stat(input int bitn, input string req);
    bit seen = 0;
    for (int i = 0; i < 20000 && !seen; i++) begin
      @(negedge clk); cfg_addr = 3'd6; #1;
      if (cfg_rdata[bitn]) seen = 1;
    end
    check(seen, req, "completion timeout", 32'(seen), 1);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] xw(input int cnt, input int sz, input int bl, input bit sw);
    return {11'd0, sw, 2'(bl), 2'(sz), 16'(cnt)};
  endfunction

  function automatic logic [7:0] pat(input int a, input int seed);
    return 8'((a * 13 + seed * 7 + 5) ^ (a >> 3));
  endfunction

  task automatic prep_mem(input int seed);
    for (int a = 32'h400; a < 32'h500; a++) mem[a] = pat(a, seed);
    for (int a = 32'h800; a < 32'h900; a++) mem[a] = 8'hEE;
  endtask

  // count destination bytes differing from the expected copy (R8, R9)
  function automatic int copy_errs(input int src, input int dst, input int cnt,
                                   input int sz, input bit sw);
    int errs = 0, eb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    for (int k = 0; k < cnt; k++)
      for (int j = 0; j < eb; j++) begin
        int sj = (sw && eb > 1) ? (eb - 1 - j) : j;
        if (mem[dst + k*eb + j] != mem[src + k*eb + sj]) errs++;
      end
    if (mem[dst + cnt*eb] != 8'hEE) errs++;
    return errs;
  endfunction

  task automatic clear_log();
    rd_reqs = 0; wr_reqs = 0; last_rd_len = 0; max_rd_len = 0;
  endtask

  task automatic run_single(input int sz, input int bl, input bit sw, input int cnt);
    int b = (bl == 0) ? 1 : (bl == 1) ? 4 : (bl == 2) ? 8 : 16;
    int nreq = (cnt + b - 1) / b;
    int lastn = cnt - (nreq - 1) * b;
    logic [31:0] st;
    prep_mem(sz * 31 + bl * 5 + cnt);
    clear_log();
    wr_reg(3'd0, 32'h400);
    wr_reg(3'd1, 32'h800);
    wr_reg(3'd2, xw(cnt, sz, bl, sw));
    wr_reg(3'd3, 32'h1);
    wait_stat(0, "R10");
    check(copy_errs(32'h400, 32'h800, cnt, sz, sw) == 0, sw ? "R9" : "R8", "copied bytes",
          32'(copy_errs(32'h400, 32'h800, cnt, sz, sw)), 0);
    check(rd_reqs == nreq && wr_reqs == nreq, "R7", "request count", 32'(rd_reqs), 32'(nreq));
    check(last_rd_len == lastn && max_rd_len <= b, "R7", "last burst length",
          32'(last_rd_len), 32'(lastn));
    check(first_rd_addr == 32'h400, "R2", "first read address", first_rd_addr, 32'h400);
    check(irq == 1'b1, "R10", "irq after copy", 32'(irq), 1);
    wr_reg(3'd6, 32'h1);
    rd_reg(3'd6, st);
    check(irq == 1'b0 && st == 32'h0, "R10", "irq after W1C", st, 0);
  endtask

  task automatic put_desc(input int idx, input int s, input int d, input logic [31:0] x, input bit v);
    int e = 32'h100 + 16 * idx;
    mem_wr(e, 2'd2, s); mem_wr(e + 4, 2'd2, d); mem_wr(e + 8, 2'd2, x); mem_wr(e + 12, 2'd2, 32'(v));
  endtask

  initial begin
    logic [31:0] st;
    rst_n = 0; cfg_we = 0; cfg_addr = 3'd6; cfg_wdata = '0;
    for (int a = 0; a < 4096; a++) mem[a] = '0;
    clear_log(); fetch_e0 = 0; fetch_e1 = 0; first_rd_addr = '0;
    repeat (4) @(negedge clk);
    #1;
    check(irq == 0 && cfg_rdata == 0, "R10", "reset status", cfg_rdata, 0);
    check(!rd_req_valid && !wr_req_valid, "R1", "reset request lines",
          32'({rd_req_valid, wr_req_valid}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // exhaustive sweep over size, burst code, swap and count
    for (int sz = 0; sz < 3; sz++)
      for (int bl = 0; bl < 4; bl++)
        for (int sw = 0; sw < 2; sw++) begin
          run_single(sz, bl, sw[0], 1);
          run_single(sz, bl, sw[0], 5);
          run_single(sz, bl, sw[0], 17);
        end

    // R11: zero-length direct copy
    clear_log();
    wr_reg(3'd2, xw(0, 2, 1, 0));
    wr_reg(3'd3, 32'h1);
    wait_stat(0, "R11");
    check(rd_reqs == 0 && wr_reqs == 0, "R11", "bus traffic for empty copy", 32'(rd_reqs + wr_reqs), 0);
    wr_reg(3'd6, 32'h1);

    // R12: restart and source change during a busy copy are ignored
    prep_mem(99);
    clear_log();
    wr_reg(3'd0, 32'h400);
    wr_reg(3'd1, 32'h800);
    wr_reg(3'd2, xw(17, 0, 0, 0));
    wr_reg(3'd3, 32'h1);
    repeat (4) @(negedge clk);
    rd_reg(3'd6, st);
    check(st[2] == 1'b1, "R12", "busy bit during copy", 32'(st[2]), 1);
    wr_reg(3'd0, 32'h440);
    wr_reg(3'd3, 32'h1);
    wait_stat(0, "R12");
    repeat (40) @(negedge clk);
    check(rd_reqs == 17, "R12", "single run despite restart", 32'(rd_reqs), 17);
    check(copy_errs(32'h400, 32'h800, 17, 0, 0) == 0, "R12", "data from latched source",
          32'(copy_errs(32'h400, 32'h800, 17, 0, 0)), 0);
    wr_reg(3'd6, 32'h1);

    // ring: three valid entries, wrap to consumed entry 0 then stall
    prep_mem(7);
    clear_log(); fetch_e0 = 0; fetch_e1 = 0;
    put_desc(0, 32'h400, 32'h800, xw(6, 2, 1, 1), 1);
    put_desc(1, 32'h440, 32'h840, xw(9, 1, 2, 0), 1);
    put_desc(2, 32'h480, 32'h880, xw(3, 0, 3, 1), 1);
    wr_reg(3'd4, 32'h100);
    wr_reg(3'd5, 32'd3);
    wr_reg(3'd3, 32'h2);
    wait_stat(1, "R4");
    check(copy_errs(32'h400, 32'h800, 6, 2, 1) == 0, "R3", "entry 0 copy", 32'(copy_errs(32'h400, 32'h800, 6, 2, 1)), 0);
    check(copy_errs(32'h440, 32'h840, 9, 1, 0) == 0, "R3", "entry 1 copy", 32'(copy_errs(32'h440, 32'h840, 9, 1, 0)), 0);
    check(copy_errs(32'h480, 32'h880, 3, 0, 1) == 0, "R9", "entry 2 byte copy ignores swap", 32'(copy_errs(32'h480, 32'h880, 3, 0, 1)), 0);
    for (int i = 0; i < 3; i++)
      check(mem_rd(32'h10C + 16 * i, 2'd2) == 32'h2, "R5", "writeback word", mem_rd(32'h10C + 16 * i, 2'd2), 32'h2);
    check(fetch_e0 == 2, "R6", "entry 0 fetched again after wrap", 32'(fetch_e0), 2);
    check(rd_reqs == 4 + 2 + 2 + 1, "R7", "ring read request count", 32'(rd_reqs), 9);
    rd_reg(3'd6, st);
    check(st == 32'h3 && irq, "R4", "stalled and idle status", st, 32'h3);
    wr_reg(3'd6, 32'h3);
    rd_reg(3'd6, st);
    check(st == 32'h0, "R4", "stall cleared by W1C", st, 0);

    // R4: restart resumes at the stalled entry
    put_desc(0, 32'h4C0, 32'h8C0, xw(4, 2, 0, 0), 1);
    wr_reg(3'd3, 32'h2);
    wait_stat(1, "R4");
    check(fetch_e0 == 3 && fetch_e1 == 2, "R4", "refetch of stalled index",
          32'(fetch_e0 * 16 + fetch_e1), 32'h32);
    check(copy_errs(32'h4C0, 32'h8C0, 4, 2, 0) == 0, "R4", "copy after restart",
          32'(copy_errs(32'h4C0, 32'h8C0, 4, 2, 0)), 0);
    check(irq == 1'b1, "R10", "irq after descriptor copy", 32'(irq), 1);

    check(bad_rd == 0 && bad_wr == 0, "R1", "master direction separation", 32'(bad_rd + bad_wr), 0);
    finish_up();
  end
endmodule